// File: doc/BRIEF.md
# Sense-Amplifier Offset Calibration Sequencer

This block runs the start-up offset calibration for a bank of sense amplifiers whose input-pair body voltages can be switched. On a calibration request it goes through three phases that never overlap. First it returns every bias select to the nominal setting. Next it fires the sense enable while the amplifier inputs are forced to ground. Last it strobes a per-amplifier capture, which records the sign of each amplifier's input-referred offset. Each recorded bit then drives that amplifier's bias select, so that the raised body voltage is applied on the side that opposes the offset.

The bank is organised as `N_BLK` blocks of `N_COL` columns. Amplifier `b*N_COL + c` occupies bit `b*N_COL + c` of both `amp_out` and `bias_sel`. The length of each phase, in clock cycles, is taken from `phase_len` when a request is accepted. Until the sequence finishes, ordinary read sense requests are held off. After it finishes they pass straight through to the sense enable.

Top module: `sacal_seq`

## Requirements
- R1: While reset is active, and in the cycle after it is released, every strobe output, `cal_done` and all bits of `bias_sel` are 0.
- R2: A `cal_req` sampled high while idle or done starts the clear phase on the next edge. During that phase `bias_clear` is high for L cycles and `bias_sel` is all zero. L is `phase_len` sampled with the request.
- R3: The cycle after the clear phase ends, the sense phase starts. In it `sense_fire` and `in_ground` are both high for exactly L cycles.
- R4: The cycle after the sense phase ends, `bias_capture` is high for L cycles. The edge that ends this phase loads `bias_sel[i]` with `amp_out[i]`. A value of 1 selects the raised body bias on the reference-input side, and a value of 0 selects it on the bit-line side.
- R5: At most one of `bias_clear`, `in_ground` and `bias_capture` is high in any cycle.
- R6: `cal_done` rises in the cycle after the capture phase ends. It stays high, with no calibration strobe active, until reset or a new request.
- R7: `bias_sel` changes only on entry to the clear phase or at the end of the capture phase. Changes on `amp_out` at any other time have no effect on it.
- R8: `rd_sense_req` drives `sense_fire` in the same cycle only while `cal_done` is high. Before that it is blocked.
- R9: A `phase_len` of 0 is treated as a length of 1 cycle.
- R10: A `cal_req` that arrives while a calibration is in progress is ignored. The phase lengths do not change.
- R11: A request made while done clears `cal_done` and `bias_sel` on entry to the clear phase, then runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibration request, sampled at the clock edge |
| phase_len | input | PW | Cycles per phase (0 is treated as 1) |
| rd_sense_req | input | 1 | Sense enable request for normal reads |
| amp_out | input | N_BLK*N_COL | Amplifier outputs, one bit per amplifier |
| bias_clear | output | 1 | Forces every body node to nominal |
| sense_fire | output | 1 | Sense enable to the amplifiers |
| in_ground | output | 1 | Forces both amplifier inputs to 0 V |
| bias_capture | output | 1 | Capture strobe for the per-amplifier latches |
| bias_sel | output | N_BLK*N_COL | Per-amplifier body-bias select |
| cal_done | output | 1 | Calibration complete |

## Verification
If the phase state or the phase counter is wrong, a strobe shows up at the ports with the wrong width or in the wrong order. The bench sees this within the L cycles of the phase concerned. A wrongly loaded or wrongly cleared bias latch shows up on `bias_sel` in the cycle after the capture or clear edge. It stays visible until the next request, so a missed update is also caught during the hold window after done. An error in the read gate shows up on `sense_fire` in the very cycle that `rd_sense_req` is raised.

// File: rtl/sacal_pkg.sv
package sacal_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CLEAR   = 3'd1,
    PH_SENSE   = 3'd2,
    PH_CAPTURE = 3'd3,
    PH_READY   = 3'd4
  } cal_phase_e;

  // Effective phase length: a programmed zero behaves as one cycle.
  function automatic logic [31:0] eff_len(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

  // Phase order of the calibration sequence.
  function automatic cal_phase_e next_phase(input cal_phase_e cur);
    case (cur)
      PH_CLEAR:   return PH_SENSE;
      PH_SENSE:   return PH_CAPTURE;
      PH_CAPTURE: return PH_READY;
      default:    return cur;
    endcase
  endfunction

  function automatic logic is_active(input cal_phase_e cur);
    return (cur == PH_CLEAR) || (cur == PH_SENSE) || (cur == PH_CAPTURE);
  endfunction

endpackage

// File: rtl/sacal_phase_ctl.sv
module sacal_phase_ctl
  import sacal_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_req,
  input  logic [PW-1:0] phase_len,
  output cal_phase_e    phase,
  output logic          phase_last,
  output logic          start_cal
);

  logic [PW-1:0] cnt;
  logic [PW-1:0] len_q;

  // A request is only accepted outside an active calibration.
  assign start_cal  = cal_req && !is_active(phase);
  assign phase_last = is_active(phase) &&
                      (32'(cnt) == (eff_len(32'(len_q)) - 32'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else if (start_cal) begin
      phase <= PH_CLEAR;
      cnt   <= '0;
      len_q <= phase_len;
    end else if (phase_last) begin
      phase <= next_phase(phase);
      cnt   <= '0;
    end else if (is_active(phase)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sacal_bias_bank.sv
module sacal_bias_bank #(
  parameter int N_BLK = 4,
  parameter int N_COL = 128,
  localparam int N_AMP = N_BLK * N_COL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [N_AMP-1:0] amp_out,
  output logic [N_AMP-1:0] bias_sel
);

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    logic [N_COL-1:0] seg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seg <= '0;
      else if (clear) seg <= '0;
      else if (load)  seg <= amp_out[b*N_COL +: N_COL];
    end

    assign bias_sel[b*N_COL +: N_COL] = seg;
  end

endmodule

// File: rtl/sacal_strobe_dec.sv
module sacal_strobe_dec
  import sacal_pkg::*;
(
  input  cal_phase_e phase,
  input  logic       rd_sense_req,
  output logic       bias_clear,
  output logic       sense_fire,
  output logic       in_ground,
  output logic       bias_capture,
  output logic       cal_done
);

  always_comb begin
    bias_clear   = (phase == PH_CLEAR);
    in_ground    = (phase == PH_SENSE);
    bias_capture = (phase == PH_CAPTURE);
    cal_done     = (phase == PH_READY);
    sense_fire   = in_ground || (cal_done && rd_sense_req);
  end

endmodule

// File: rtl/sacal_seq.sv
module sacal_seq
  import sacal_pkg::*;
#(
  parameter int N_BLK = 4,
  parameter int N_COL = 128,
  parameter int PW    = 4,
  localparam int N_AMP = N_BLK * N_COL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_req,
  input  logic [PW-1:0]    phase_len,
  input  logic             rd_sense_req,
  input  logic [N_AMP-1:0] amp_out,
  output logic             bias_clear,
  output logic             sense_fire,
  output logic             in_ground,
  output logic             bias_capture,
  output logic [N_AMP-1:0] bias_sel,
  output logic             cal_done
);

  cal_phase_e phase;
  logic       phase_last;
  logic       start_cal;
  logic       cap_fire;

  sacal_phase_ctl #(.PW(PW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_req    (cal_req),
    .phase_len  (phase_len),
    .phase      (phase),
    .phase_last (phase_last),
    .start_cal  (start_cal)
  );

  assign cap_fire = phase_last && (phase == PH_CAPTURE);

  sacal_bias_bank #(.N_BLK(N_BLK), .N_COL(N_COL)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_cal),
    .load     (cap_fire),
    .amp_out  (amp_out),
    .bias_sel (bias_sel)
  );

  sacal_strobe_dec u_dec (
    .phase        (phase),
    .rd_sense_req (rd_sense_req),
    .bias_clear   (bias_clear),
    .sense_fire   (sense_fire),
    .in_ground    (in_ground),
    .bias_capture (bias_capture),
    .cal_done     (cal_done)
  );

endmodule

// File: rtl/sacal_chk.sv
module sacal_chk #(
  parameter int N_AMP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bias_clear,
  input logic             sense_fire,
  input logic             in_ground,
  input logic             bias_capture,
  input logic [N_AMP-1:0] bias_sel,
  input logic             cal_done
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bias_clear, in_ground, bias_capture}));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bias_clear |-> (bias_sel == '0));

  // R3
  clr_to_sns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_clear) |-> (sense_fire && in_ground));

  // R4
  sns_to_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ground) |-> bias_capture);

  // R6
  done_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_capture) |-> cal_done);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !(bias_clear || in_ground || bias_capture));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bias_sel) |-> (bias_clear || $past(bias_capture)));

  // R8
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_fire && !cal_done) |-> in_ground);

endmodule

bind sacal_seq sacal_chk #(.N_AMP(N_AMP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bias_clear   (bias_clear),
  .sense_fire   (sense_fire),
  .in_ground    (in_ground),
  .bias_capture (bias_capture),
  .bias_sel     (bias_sel),
  .cal_done     (cal_done)
);

// File: tb/tb_sacal_seq.sv
module tb_sacal_seq;

  localparam int NB = 2;
  localparam int NC = 4;
  localparam int NA = NB * NC;
  localparam int PWB = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cal_req = 1'b0;
  logic [PWB-1:0] phase_len = '0;
  logic           rd_sense_req = 1'b0;
  logic [NA-1:0]  amp_out = '0;
  logic           bias_clear, sense_fire, in_ground, bias_capture, cal_done;
  logic [NA-1:0]  bias_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sacal_seq #(.N_BLK(NB), .N_COL(NC), .PW(PWB)) dut (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .phase_len(phase_len),
    .rd_sense_req(rd_sense_req), .amp_out(amp_out),
    .bias_clear(bias_clear), .sense_fire(sense_fire), .in_ground(in_ground),
    .bias_capture(bias_capture), .bias_sel(bias_sel), .cal_done(cal_done)
  );

  task automatic chk(input bit c, input string msg, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {bias_clear, sense_fire, in_ground, bias_capture};
  endfunction

  task automatic run_cal(input logic [NA-1:0] pat, input logic [PWB-1:0] len,
                         input bit rd_on, input bit poke);
    int L;
    int good;
    L = (len == 0) ? 1 : int'(len);
    @(negedge clk);
    phase_len = len; amp_out = ~pat; rd_sense_req = rd_on; cal_req = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    good = 0;
    for (int i = 0; i < L; i++) begin
      if (strobes() == 4'b1000 && bias_sel == '0 && !cal_done) good++;
      @(negedge clk);
    end
    // R2 R11 R9: clear phase of L cycles, selects zero, done dropped
    chk(good == L, "R2/R11 clear phase", good, L);
    good = 0;
    for (int i = 0; i < L; i++) begin
      if (strobes() == 4'b0110) good++;
      if (poke && i == 0) cal_req = 1'b1;
      if (i == L - 1) amp_out = pat;
      @(negedge clk);
      cal_req = 1'b0;
    end
    // R3 R10: sense phase of L cycles, mid-run request ignored
    chk(good == L, "R3/R10 sense phase", good, L);
    good = 0;
    for (int i = 0; i < L; i++) begin
      // R8: read request blocked while capturing
      if (strobes() == 4'b0001 && !cal_done) good++;
      @(negedge clk);
    end
    chk(good == L, "R4/R8 capture phase", good, L);
    chk(bias_sel == pat, "R4 captured selects", 32'(bias_sel), 32'(pat));
    chk(cal_done && !bias_clear && !in_ground && !bias_capture,
        "R6 done after capture", {28'd0, cal_done, bias_clear, in_ground, bias_capture}, 32'h8);
    chk(sense_fire == rd_on, "R8 read sense pass after done", 32'(sense_fire), 32'(rd_on));
    amp_out = ~pat;
    repeat (3) @(negedge clk);
    chk(bias_sel == pat && cal_done, "R7 hold after done", 32'(bias_sel), 32'(pat));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    amp_out = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(strobes() == 4'b0000 && bias_sel == '0 && !cal_done, "R1 during reset",
        {strobes(), bias_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sense_req = 1'b1;
    amp_out = 8'h5a;
    @(negedge clk);
    chk(strobes() == 4'b0000 && bias_sel == '0 && !cal_done, "R1/R8 idle after reset",
        {strobes(), bias_sel}, 0);
    rd_sense_req = 1'b0;

    for (int p = 0; p < 256; p++) begin
      run_cal(NA'(p), PWB'(p % 6), p[0], p[1]);
    end
    // R9 explicit zero length
    run_cal(8'hc3, 4'd0, 1'b1, 1'b0);
    run_cal(8'h3c, 4'd15, 1'b0, 1'b1);

    // R1: reset in the middle of a calibration
    @(negedge clk);
    phase_len = 4'd4; cal_req = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(strobes() == 4'b0000 && bias_sel == '0 && !cal_done, "R1 mid-run reset",
        {strobes(), bias_sel}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cal_done && bias_sel == '0, "R1 after mid-run reset", 32'(bias_sel), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule